// File: doc/BRIEF.md
# SPI Pin Direction and Select Control

This block sits between an SPI shift register and the package pins. It decides, cycle by cycle, which pins the SPI drives and which it listens to. It does this for two pin arrangements. The first is the usual four-wire arrangement: clock, master-out, master-in and select. The second is a single-wire bidirectional arrangement, in which one data pin carries traffic in both directions. It also holds the master/slave role bit. Other logic writes that bit, and a detected mode fault clears it.

When the select-output feature is active, the block drives the select pin itself: low for the whole time a transfer runs, high while idle. When the feature is off and the fault enable is set, a master watches its select pin through a synchronizer. If another master pulls that pin low, the block drops back to slave, raises a sticky fault flag and emits a one-cycle event. Every pin then follows the slave arrangement at once.

Top module: `spi_pinctl`

## Requirements
- R1: After reset, roleMaster and faultFlag are 0 and mosiOe, sckOe, ssOe are 0; misoOe is 0 while ssIn is high.
- R2: A cycle with roleWrEn high loads roleWrVal into roleMaster at the next clock edge.
- R3: Four-wire master (roleMaster=1, bidirEn=0): mosiOe=1 and mosiOut=txBit, sckOe=1 and sckOut=sckGen, misoOe=0, rxBit=misoIn.
- R4: Four-wire slave (roleMaster=0, bidirEn=0): mosiOe=0, sckOe=0, rxBit=mosiIn, misoOut=txBit, and misoOe=1 exactly while ssIn is low.
- R5: When roleMaster, faultEn and ssOutEn are all 1, ssOe=1 and ssOut is the inverse of xferActive.
- R6: In every other case ssOe=0. This includes a slave with ssOutEn=1, and a master with only one of faultEn or ssOutEn set.
- R7: For a master with faultEn=1 and ssOutEn=0, ssIn held low is synchronized through SYNC_STAGES flops. On the following edge, roleMaster clears, faultFlag sets and modeFault pulses high for exactly one cycle. That is SYNC_STAGES+1 edges after ssIn falls.
- R8: No fault is raised when ssOutEn=1, when faultEn=0, or when the block is a slave, whatever ssIn does.
- R9: faultFlag stays set until a faultClr cycle. If a fault and faultClr land on the same edge, the flag stays set.
- R10: Bidirectional master (bidirEn=1): MOSI is the shared pin with mosiOe=dirOut and mosiOut=txBit, rxBit=mosiIn, misoOe=0.
- R11: Bidirectional slave: MISO is the shared pin with misoOe=dirOut while ssIn is low, rxBit=misoIn, mosiOe=0.
- R12: After a fault, the pins follow the slave arrangement of the current bidirEn setting.
- R13: A fault beats a roleWrEn write of 1 on the same edge, so roleMaster ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| roleWrEn | input | 1 | Write strobe for the role bit |
| roleWrVal | input | 1 | Role value written (1 = master) |
| bidirEn | input | 1 | Select single-wire bidirectional mode |
| ssOutEn | input | 1 | Request automatic select output |
| faultEn | input | 1 | Enable mode-fault logic / select output |
| dirOut | input | 1 | Shared-pin direction in bidirectional mode (1 = drive) |
| faultClr | input | 1 | Clear the sticky fault flag |
| xferActive | input | 1 | A transfer is running |
| txBit | input | 1 | Serial data from the shifter |
| sckGen | input | 1 | Serial clock from the baud generator |
| mosiIn | input | 1 | MOSI pin input |
| misoIn | input | 1 | MISO pin input |
| ssIn | input | 1 | Select pin input |
| mosiOut | output | 1 | MOSI pin output value |
| mosiOe | output | 1 | MOSI pin output enable |
| misoOut | output | 1 | MISO pin output value |
| misoOe | output | 1 | MISO pin output enable |
| sckOut | output | 1 | Clock pin output value |
| sckOe | output | 1 | Clock pin output enable |
| ssOut | output | 1 | Select pin output value |
| ssOe | output | 1 | Select pin output enable |
| rxBit | output | 1 | Serial data delivered to the shifter |
| roleMaster | output | 1 | Current role (1 = master) |
| faultFlag | output | 1 | Sticky mode-fault flag |
| modeFault | output | 1 | One-cycle mode-fault event |

## Verification
The bench targets the fault timing. It checks that roleMaster is still set one edge before the synchronized low arrives and is cleared exactly on the expected edge. A design that skipped or added a synchronizer stage would fail here. It drives ssIn low under select-output, under a disabled fault enable and as a slave, to catch a design that ignores the gating and falls out of master mode by mistake. It also collides a fault with a master write and with a flag clear, where a wrong priority would leave the block a master or drop the flag. Every pin mapping is swept in all four mode combinations and with both direction values, which exposes a swapped shared pin or a MISO driver left on in master mode.

// File: rtl/spi_pinctl_pkg.sv
package spi_pinctl_pkg;
  typedef struct packed {
    logic isMaster;
    logic bidir;
    logic ssAuto;
    logic dirOut;
  } ctrlStrobes_t;
endpackage

// File: rtl/spi_pinctl_ctrl.sv
module spi_pinctl_ctrl
  import spi_pinctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         roleWrEn,
  input  logic         roleWrVal,
  input  logic         bidirEn,
  input  logic         ssOutEn,
  input  logic         faultEn,
  input  logic         dirOut,
  input  logic         faultClr,
  input  logic         ssIn,
  output ctrlStrobes_t strobes,
  output logic         roleMaster,
  output logic         faultFlag,
  output logic         modeFault
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] ssSyncQ;
  logic              ssSampled;
  logic              faultDet;
  logic              masterQ;

  // Select-pin synchronizer; idle level is high.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ssSyncQ <= '1;
        else       ssSyncQ <= ssIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ssSyncQ <= '1;
        else       ssSyncQ <= {ssSyncQ[SYNC_MSB-1:0], ssIn};
      end
    end
  endgenerate

  assign ssSampled = ssSyncQ[SYNC_MSB];

  // Fault is only watched when the select pin is an input of a master.
  assign faultDet = masterQ && faultEn && !ssOutEn && !ssSampled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterQ   <= 1'b0;
      faultFlag <= 1'b0;
      modeFault <= 1'b0;
    end else begin
      modeFault <= faultDet;
      if (faultDet)      masterQ <= 1'b0;
      else if (roleWrEn) masterQ <= roleWrVal;
      if (faultDet)      faultFlag <= 1'b1;
      else if (faultClr) faultFlag <= 1'b0;
    end
  end

  assign roleMaster       = masterQ;
  assign strobes.isMaster = masterQ;
  assign strobes.bidir    = bidirEn;
  assign strobes.ssAuto   = masterQ && faultEn && ssOutEn;
  assign strobes.dirOut   = dirOut;
endmodule

// File: rtl/spi_pinctl_dp.sv
module spi_pinctl_dp
  import spi_pinctl_pkg::*;
(
  input  ctrlStrobes_t strobes,
  input  logic         xferActive,
  input  logic         txBit,
  input  logic         sckGen,
  input  logic         mosiIn,
  input  logic         misoIn,
  input  logic         ssIn,
  output logic         mosiOut,
  output logic         mosiOe,
  output logic         misoOut,
  output logic         misoOe,
  output logic         sckOut,
  output logic         sckOe,
  output logic         ssOut,
  output logic         ssOe,
  output logic         rxBit
);
  logic selected;
  assign selected = !ssIn;

  always_comb begin
    mosiOut = txBit;
    misoOut = txBit;
    sckOut  = sckGen;
    mosiOe  = 1'b0;
    misoOe  = 1'b0;
    sckOe   = strobes.isMaster;
    ssOe    = strobes.ssAuto;
    ssOut   = !xferActive;
    rxBit   = 1'b0;
    unique case ({strobes.isMaster, strobes.bidir})
      2'b10: begin mosiOe = 1'b1;                       rxBit = misoIn; end
      2'b11: begin mosiOe = strobes.dirOut;             rxBit = mosiIn; end
      2'b00: begin misoOe = selected;                   rxBit = mosiIn; end
      2'b01: begin misoOe = strobes.dirOut && selected; rxBit = misoIn; end
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_pinctl.sv
module spi_pinctl
  import spi_pinctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic roleWrEn,
  input  logic roleWrVal,
  input  logic bidirEn,
  input  logic ssOutEn,
  input  logic faultEn,
  input  logic dirOut,
  input  logic faultClr,
  input  logic xferActive,
  input  logic txBit,
  input  logic sckGen,
  input  logic mosiIn,
  input  logic misoIn,
  input  logic ssIn,
  output logic mosiOut,
  output logic mosiOe,
  output logic misoOut,
  output logic misoOe,
  output logic sckOut,
  output logic sckOe,
  output logic ssOut,
  output logic ssOe,
  output logic rxBit,
  output logic roleMaster,
  output logic faultFlag,
  output logic modeFault
);
  ctrlStrobes_t strobes;

  spi_pinctl_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .roleWrEn(roleWrEn), .roleWrVal(roleWrVal),
    .bidirEn(bidirEn), .ssOutEn(ssOutEn), .faultEn(faultEn), .dirOut(dirOut),
    .faultClr(faultClr), .ssIn(ssIn), .strobes(strobes),
    .roleMaster(roleMaster), .faultFlag(faultFlag), .modeFault(modeFault)
  );

  spi_pinctl_dp dp_i (
    .strobes(strobes), .xferActive(xferActive), .txBit(txBit), .sckGen(sckGen),
    .mosiIn(mosiIn), .misoIn(misoIn), .ssIn(ssIn),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoOut(misoOut), .misoOe(misoOe),
    .sckOut(sckOut), .sckOe(sckOe), .ssOut(ssOut), .ssOe(ssOe), .rxBit(rxBit)
  );
endmodule

// File: rtl/spi_pinctl_chk.sv
module spi_pinctl_chk (
  input logic clk,
  input logic rstN,
  input logic ssOutEn,
  input logic faultEn,
  input logic bidirEn,
  input logic xferActive,
  input logic mosiOe,
  input logic misoOe,
  input logic sckOe,
  input logic ssOut,
  input logic ssOe,
  input logic roleMaster,
  input logic faultFlag,
  input logic modeFault
);
  // R5: automatic select drives low during a transfer, high when idle
  p_ss_auto_r5: assert property (@(posedge clk) disable iff (!rstN)
    (roleMaster && faultEn && ssOutEn) |-> (ssOe && (ssOut == !xferActive)));

  // R6: a slave never drives the select pin
  p_ss_slave_in_r6: assert property (@(posedge clk) disable iff (!rstN)
    !roleMaster |-> !ssOe);

  // R8: a fault event needs an armed master watching its select input
  p_fault_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |-> $past(roleMaster && faultEn && !ssOutEn));

  // R7: a fault event leaves a slave with the flag set, one cycle long
  p_fault_effect_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |-> (!roleMaster && faultFlag));
  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> !modeFault);

  // R3: a master never drives MISO
  p_master_miso_r3: assert property (@(posedge clk) disable iff (!rstN)
    roleMaster |-> !misoOe);

  // R4: a slave never drives MOSI or the clock
  p_slave_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    !roleMaster |-> (!mosiOe && !sckOe));

  // R11: in bidirectional slave mode MOSI stays released
  p_bidir_slave_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!roleMaster && bidirEn) |-> !mosiOe);
endmodule

bind spi_pinctl spi_pinctl_chk chk_i (
  .clk(clk), .rstN(rstN), .ssOutEn(ssOutEn), .faultEn(faultEn),
  .bidirEn(bidirEn), .xferActive(xferActive), .mosiOe(mosiOe),
  .misoOe(misoOe), .sckOe(sckOe), .ssOut(ssOut), .ssOe(ssOe),
  .roleMaster(roleMaster), .faultFlag(faultFlag), .modeFault(modeFault)
);

// File: tb/spi_pinctl_tb_top.sv
module spi_pinctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic roleWrEn = 0, roleWrVal = 0, bidirEn = 0, ssOutEn = 0, faultEn = 0;
  logic dirOut = 0, faultClr = 0, xferActive = 0, txBit = 0, sckGen = 0;
  logic mosiIn = 0, misoIn = 0, ssIn = 1;
  logic mosiOut, mosiOe, misoOut, misoOe, sckOut, sckOe, ssOut, ssOe;
  logic rxBit, roleMaster, faultFlag, modeFault;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pinctl #(.SYNC_STAGES(SYNC)) dut_i (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setRole(input logic v);
    roleWrEn = 1; roleWrVal = v; step(); roleWrEn = 0;
  endtask

  task automatic t_reset();
    chk("R1 roleMaster", roleMaster, 0); chk("R1 faultFlag", faultFlag, 0);
    chk("R1 mosiOe", mosiOe, 0); chk("R1 sckOe", sckOe, 0);
    chk("R1 ssOe", ssOe, 0); chk("R1 misoOe", misoOe, 0);
  endtask

  task automatic t_master4();
    setRole(1);
    chk("R2 roleMaster set", roleMaster, 1);
    for (int i = 0; i < 4; i++) begin
      txBit = i[0]; sckGen = i[1]; misoIn = ~i[0]; mosiIn = i[0]; #1;
      chk("R3 mosiOe", mosiOe, 1); chk("R3 mosiOut", mosiOut, i[0]);
      chk("R3 sckOe", sckOe, 1); chk("R3 sckOut", sckOut, i[1]);
      chk("R3 misoOe", misoOe, 0); chk("R3 rxBit", rxBit, ~i[0]);
    end
  endtask

  task automatic t_ssAuto();
    faultEn = 1; ssOutEn = 1; xferActive = 0; #1;
    chk("R5 ssOe", ssOe, 1); chk("R5 ssOut idle", ssOut, 1);
    xferActive = 1; #1; chk("R5 ssOut xfer", ssOut, 0);
    faultEn = 0; #1; chk("R6 only ssOutEn", ssOe, 0);
    faultEn = 1; ssOutEn = 0; #1; chk("R6 only faultEn", ssOe, 0);
    // R8: select output on, ssIn low must not fault
    ssOutEn = 1; ssIn = 0; repeat (SYNC + 2) step();
    chk("R8 ssOutEn blocks fault", roleMaster, 1); chk("R8 flag", faultFlag, 0);
    // R8: fault disabled
    faultEn = 0; ssOutEn = 0; repeat (SYNC + 2) step();
    chk("R8 faultEn=0 blocks fault", roleMaster, 1);
    ssIn = 1; xferActive = 0; repeat (SYNC + 1) step();
  endtask

  task automatic t_fault();
    faultEn = 1; ssOutEn = 0; bidirEn = 0;
    ssIn = 0; repeat (SYNC) step();
    chk("R7 still master before sync", roleMaster, 1);
    chk("R7 no pulse yet", modeFault, 0);
    step();
    chk("R7 master cleared", roleMaster, 0); chk("R7 flag", faultFlag, 1);
    chk("R7 pulse", modeFault, 1);
    #1; chk("R12 mosiOe released", mosiOe, 0); chk("R12 misoOe slave", misoOe, 1);
    step(); chk("R7 pulse one cycle", modeFault, 0);
    chk("R9 sticky", faultFlag, 1);
    faultClr = 1; step(); faultClr = 0;
    chk("R9 cleared", faultFlag, 0);
    ssIn = 1; repeat (SYNC + 1) step();
  endtask

  task automatic t_collide();
    setRole(1);
    ssIn = 0; repeat (SYNC) step();
    roleWrEn = 1; roleWrVal = 1; faultClr = 1; step();
    roleWrEn = 0; faultClr = 0;
    chk("R13 fault beats write", roleMaster, 0);
    chk("R9 set beats clear", faultFlag, 1);
    ssIn = 1; repeat (SYNC + 1) step();
    faultClr = 1; step(); faultClr = 0;
  endtask

  task automatic t_slave4();
    setRole(0); bidirEn = 0; ssOutEn = 1; faultEn = 1; ssIn = 1; #1;
    chk("R6 slave ignores ssOutEn", ssOe, 0);
    chk("R4 misoOe unselected", misoOe, 0);
    ssIn = 0; txBit = 1; mosiIn = 1; misoIn = 0; #1;
    chk("R4 misoOe selected", misoOe, 1); chk("R4 misoOut", misoOut, 1);
    chk("R4 rxBit", rxBit, 1); chk("R4 mosiOe", mosiOe, 0); chk("R4 sckOe", sckOe, 0);
    ssOutEn = 0; repeat (SYNC + 2) step();
    chk("R8 slave no fault", faultFlag, 0);
    ssIn = 1; repeat (SYNC + 1) step();
  endtask

  task automatic t_bidir();
    faultEn = 0; ssOutEn = 0; bidirEn = 1; setRole(1);
    for (int d = 0; d < 2; d++) begin
      dirOut = d[0]; mosiIn = 1; misoIn = 0; txBit = 1; #1;
      chk("R10 mosiOe dir", mosiOe, d[0]); chk("R10 mosiOut", mosiOut, 1);
      chk("R10 rxBit", rxBit, 1); chk("R10 misoOe", misoOe, 0);
    end
    setRole(0); ssIn = 0;
    for (int d = 0; d < 2; d++) begin
      dirOut = d[0]; mosiIn = 0; misoIn = 1; #1;
      chk("R11 misoOe dir", misoOe, d[0]); chk("R11 rxBit", rxBit, 1);
      chk("R11 mosiOe", mosiOe, 0);
    end
    ssIn = 1; #1; chk("R11 unselected", misoOe, 0);
    // R12: fault in bidirectional master moves the shared pin to MISO
    setRole(1); faultEn = 1; dirOut = 1; ssIn = 0; repeat (SYNC + 1) step();
    chk("R12 fault slave", roleMaster, 0);
    #1; chk("R12 misoOe shared", misoOe, 1); chk("R12 mosiOe", mosiOe, 0);
    ssIn = 1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rstN = 1; step();
    t_reset();
    t_master4();
    t_ssAuto();
    t_fault();
    t_collide();
    t_slave4();
    t_bidir();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule